// File: doc/BRIEF.md
# PRP Scatter Segment Walker

This block converts a host transfer descriptor into a stream of scatter segments. The descriptor is a byte count and two physical region pointers. The walker emits one (address, length) pair per segment until the byte count is covered. When the data spans more than two pages, the second pointer names a list of 64-bit pointer entries. The walker reads those entries one word at a time through a simple memory read request/response port. Along the way it follows chain entries that link one list page to the next.

The page size is configurable at run time by a small exponent input. A walk starts with a one-cycle `start` pulse while the block is idle. The walk ends with a one-cycle `done` pulse. If a pointer is found invalid, `done` comes together with `fail` and a do-not-retry marker `fail_dnr`. Segments leave through a valid/ready handshake, and the walker waits while the consumer holds off.

Top module: `prp_walker`

## Requirements
- R1: The page size is 2^(BASE_SHIFT + mps) bytes, with `mps` sampled at `start`. The offset mask is page size minus 1. The walk behaves as below for every `mps` value.
- R2: A zero first pointer ends the walk with `fail` and `fail_dnr`, with no segment and no read request.
- R3: With a nonzero first pointer, a zero byte count ends the walk with `done` and no segment. Otherwise the first segment is (first pointer, min(count, page − first pointer mod page)).
- R4: If bytes remain after the first segment and the second pointer is zero, the walk fails after that segment.
- R5: If the remainder after the first segment is at most one page, the second pointer must be page aligned. It then becomes one segment of the whole remainder. If it is not aligned, the walk fails.
- R6: If the remainder exceeds one page, entry i of the current list is read at list address + 8·i, one 64-bit word per request. Each data entry produces the segment (entry, min(remaining, page)).
- R7: When the entry index reaches page/8 − 1 while more than one page remains, that entry is the address of the next list. The index restarts at 0 there. If at most one page remains, the same slot is a data entry.
- R8: A list entry that is zero or not page aligned, whether a data or chain entry, ends the walk with `fail`. No further segment or read request follows.
- R9: Only entries that are consumed are read. The number of read requests equals the number of data entries used plus the number of chain entries followed.
- R10: While `seg_valid` is high and `seg_ready` low, the segment outputs hold. While `rd_req_valid` is high and `rd_req_ready` low, the request address holds.
- R11: `done` is a one-cycle pulse after the last segment is accepted or on failure. `fail_dnr` equals `fail`, and both are low except together with `done`. After reset the block is idle with all valid and status outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (honoured when idle) |
| mps | input | MPS_W | Page size exponent above BASE_SHIFT |
| xfer_len | input | LEN_W | Transfer length in bytes |
| ptr_first | input | ADDR_W | First region pointer |
| ptr_second | input | ADDR_W | Second region pointer or list pointer |
| busy | output | 1 | A walk is in progress |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| rd_req_valid | output | 1 | List entry read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the 64-bit entry |
| rd_rsp_valid | input | 1 | Read data is valid |
| rd_rsp_data | input | 64 | Entry value, little-endian word |
| done | output | 1 | Walk finished (pulse) |
| fail | output | 1 | Walk ended on an invalid pointer |
| fail_dnr | output | 1 | Do-not-retry marker of the failure |

## Verification
The hardest case to reach from the ports is a chain entry: the last slot of a list page that holds the next list address. It only counts as a chain while more than one page of data remains. It matters most when the chain entry is itself the bad entry. The bench uses a tiny page (32 bytes, four entries per list page), so chains appear after a few hundred bytes. It sweeps lengths across and past every chain boundary, builds the lists in a memory model, and then corrupts each written entry in turn, data and chain alike, with a zero or a misaligned value.

// File: rtl/prp_walker_pkg.sv
package prp_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEG  = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_DONE = 3'd4,
        ST_FAIL = 3'd5
    } wstate_e;

    typedef enum logic [1:0] {
        MD_FIRST  = 2'd0,
        MD_DIRECT = 2'd1,
        MD_LIST   = 2'd2
    } wmode_e;

endpackage

// File: rtl/prp_geom.sv
// Page geometry derived from the run-time page exponent.
module prp_geom #(
    parameter int ADDR_W     = 64,
    parameter int MPS_W      = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic [MPS_W-1:0]  mps,
    output logic [ADDR_W-1:0] page_size,
    output logic [ADDR_W-1:0] off_mask,
    output logic [ADDR_W-1:0] slot_last
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        page_size = ONE << (BASE_SHIFT + int'(mps));
        off_mask  = page_size - ONE;
        slot_last = (page_size >> 3) - ONE;
    end
endmodule

// File: rtl/prp_ptr_ok.sv
// A pointer is usable when it is nonzero and sits on a page boundary.
module prp_ptr_ok #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] off_mask,
    output logic              ok
);
    always_comb ok = (ptr != '0) && ((ptr & off_mask) == '0);
endmodule

// File: rtl/prp_walker.sv
module prp_walker
    import prp_walker_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LEN_W      = 32,
    parameter int MPS_W      = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MPS_W-1:0]  mps,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] ptr_first,
    input  logic [ADDR_W-1:0] ptr_second,
    output logic              busy,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [63:0]       rd_rsp_data,
    output logic              done,
    output logic              fail,
    output logic              fail_dnr
);
    localparam int IDX_W = LEN_W;

    typedef struct packed {
        wstate_e            state;
        wmode_e             mode;
        logic [MPS_W-1:0]   mps;
        logic [LEN_W-1:0]   remain;
        logic [ADDR_W-1:0]  ptr2;
        logic [ADDR_W-1:0]  list_addr;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  seg_addr;
        logic [LEN_W-1:0]   seg_len;
    } walk_t;

    walk_t r_q, r_d;

    // geometry: live input while idle, latched value during a walk
    logic [MPS_W-1:0]  geom_mps;
    logic [ADDR_W-1:0] page_size, off_mask, slot_last;

    assign geom_mps = (r_q.state == ST_IDLE) ? mps : r_q.mps;

    prp_geom #(
        .ADDR_W(ADDR_W), .MPS_W(MPS_W), .BASE_SHIFT(BASE_SHIFT)
    ) u_geom (
        .mps(geom_mps), .page_size(page_size),
        .off_mask(off_mask), .slot_last(slot_last)
    );

    logic p2_ok, ent_ok;

    prp_ptr_ok #(.ADDR_W(ADDR_W)) u_chk_p2 (
        .ptr(r_q.ptr2), .off_mask(off_mask), .ok(p2_ok)
    );

    prp_ptr_ok #(.ADDR_W(ADDR_W)) u_chk_ent (
        .ptr(ADDR_W'(rd_rsp_data)), .off_mask(off_mask), .ok(ent_ok)
    );

    // arithmetic helpers
    logic [ADDR_W-1:0] room_first;
    logic [LEN_W-1:0]  first_len;
    logic [LEN_W-1:0]  rem_after;
    logic [ADDR_W-1:0] rem_after_w, rem_w;
    logic [LEN_W-1:0]  page_chunk;

    always_comb begin
        room_first  = page_size - (ptr_first & off_mask);
        first_len   = (ADDR_W'(xfer_len) < room_first) ? xfer_len : LEN_W'(room_first);
        rem_after   = r_q.remain - r_q.seg_len;
        rem_after_w = ADDR_W'(rem_after);
        rem_w       = ADDR_W'(r_q.remain);
        page_chunk  = (rem_w > page_size) ? LEN_W'(page_size) : r_q.remain;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.mps    = mps;
                    r_d.remain = xfer_len;
                    r_d.ptr2   = ptr_second;
                    r_d.mode   = MD_FIRST;
                    r_d.idx    = '0;
                    if (ptr_first == '0) begin
                        r_d.state = ST_FAIL;
                    end else if (xfer_len == '0) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.seg_addr = ptr_first;
                        r_d.seg_len  = first_len;
                        r_d.state    = ST_SEG;
                    end
                end
            end
            ST_SEG: begin
                if (seg_ready) begin
                    r_d.remain = rem_after;
                    if (rem_after == '0) begin
                        r_d.state = ST_DONE;
                    end else if (r_q.mode == MD_FIRST) begin
                        if (r_q.ptr2 == '0) begin
                            r_d.state = ST_FAIL;
                        end else if (rem_after_w <= page_size) begin
                            if (!p2_ok) begin
                                r_d.state = ST_FAIL;
                            end else begin
                                r_d.seg_addr = r_q.ptr2;
                                r_d.seg_len  = rem_after;
                                r_d.mode     = MD_DIRECT;
                            end
                        end else begin
                            r_d.list_addr = r_q.ptr2;
                            r_d.idx       = '0;
                            r_d.mode      = MD_LIST;
                            r_d.state     = ST_REQ;
                        end
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (rd_req_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!ent_ok) begin
                        r_d.state = ST_FAIL;
                    end else if ((ADDR_W'(r_q.idx) == slot_last) && (rem_w > page_size)) begin
                        r_d.list_addr = ADDR_W'(rd_rsp_data);
                        r_d.idx       = '0;
                        r_d.state     = ST_REQ;
                    end else begin
                        r_d.seg_addr = ADDR_W'(rd_rsp_data);
                        r_d.seg_len  = page_chunk;
                        r_d.state    = ST_SEG;
                    end
                end
            end
            ST_DONE, ST_FAIL: r_d.state = ST_IDLE;
            default:          r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign seg_valid    = (r_q.state == ST_SEG);
    assign seg_addr     = r_q.seg_addr;
    assign seg_len      = r_q.seg_len;
    assign rd_req_valid = (r_q.state == ST_REQ);
    assign rd_req_addr  = r_q.list_addr + ADDR_W'({r_q.idx, 3'b000});
    assign done         = (r_q.state == ST_DONE) || (r_q.state == ST_FAIL);
    assign fail         = (r_q.state == ST_FAIL);
    assign fail_dnr     = (r_q.state == ST_FAIL);

endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              done,
    input logic              fail,
    input logic              fail_dnr
);
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R10

    AST_SEG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) && (seg_addr != '0)); // R6

    AST_FAIL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done && fail_dnr); // R11

    AST_DNR_ONLY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fail_dnr |-> fail); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_HALT_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !seg_valid && !rd_req_valid); // R8
endmodule

bind prp_walker prp_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_prp_walker_chk (.*);

// File: tb/prp_walker_test.sv
`timescale 1ns/1ps
module prp_walker_test;
    localparam int AW = 64;
    localparam int LW = 32;
    localparam int MW = 2;
    localparam int BS = 5;
    localparam logic [63:0] LIST_BASE   = 64'h0001_0000;
    localparam logic [63:0] DATA_BASE   = 64'h0080_0000;
    localparam logic [63:0] DIRECT_ADDR = 64'h0002_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [MW-1:0] mps = '0;
    logic [LW-1:0] xfer_len = '0;
    logic [AW-1:0] ptr_first = '0, ptr_second = '0;
    logic busy, seg_valid, rd_req_valid, done, fail, fail_dnr;
    logic seg_ready = 1'b0;
    logic [AW-1:0] seg_addr, rd_req_addr;
    logic [LW-1:0] seg_len;
    logic rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;

    always #2.5 clk = ~clk;

    prp_walker #(.ADDR_W(AW), .LEN_W(LW), .MPS_W(MW), .BASE_SHIFT(BS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mps(mps), .xfer_len(xfer_len),
        .ptr_first(ptr_first), .ptr_second(ptr_second), .busy(busy),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .rd_req_valid(rd_req_valid), .rd_req_ready(1'b1), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .done(done), .fail(fail), .fail_dnr(fail_dnr));

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [logic [63:0]];
    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // expected and captured streams
    logic [63:0] exp_a [0:255];
    logic [31:0] exp_l [0:255];
    int exp_n, exp_reads;
    bit exp_fail;
    logic [63:0] cap_a [0:255];
    logic [31:0] cap_l [0:255];
    int cap_n, req_cnt, done_cnt;
    bit got_fail, dnr_bad, stall;
    int rdy_ctr = 0;
    bit pend = 0;
    int dly = 0;
    logic [63:0] pend_addr;

    // entries written by the list builder
    logic [63:0] ent_at [0:255];
    int ent_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // consumer, memory responder and status monitor, all away from the active edge
    always @(negedge clk) begin
        bit nr;
        nr = stall ? ((rdy_ctr % 3) != 0) : 1'b1;
        rdy_ctr++;
        seg_ready = nr;
        if (seg_valid && nr && cap_n < 256) begin
            cap_a[cap_n] = seg_addr;
            cap_l[cap_n] = seg_len;
            cap_n++;
        end
        if (rd_rsp_valid) begin
            rd_rsp_valid = 1'b0;
        end else if (pend) begin
            if (dly == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = rd(pend_addr);
                pend = 0;
            end else dly--;
        end
        if (rd_req_valid) begin
            pend = 1;
            pend_addr = rd_req_addr;
            dly = rdy_ctr % 3;
            req_cnt++;
        end
        if (done) begin
            done_cnt++;
            if (fail) got_fail = 1;
            if (fail_dnr != fail) dnr_bad = 1;
        end
        if (!done && (fail || fail_dnr)) dnr_bad = 1;
    end

    task automatic push_exp(input logic [63:0] a, input logic [31:0] l);
        if (exp_n < 256) begin
            exp_a[exp_n] = a;
            exp_l[exp_n] = l;
        end
        exp_n++;
    endtask

    // arithmetic reference of the walk
    task automatic model(input logic [31:0] len, input logic [63:0] p1, input logic [63:0] p2,
                         input int mi);
        logic [63:0] page, mask, la, e, first, rem, sl;
        int epp, i;
        page = 64'(32) << mi;
        mask = page - 1;
        epp  = int'(page / 8);
        exp_n = 0; exp_reads = 0; exp_fail = 0;
        if (p1 == 0) begin exp_fail = 1; return; end
        if (len == 0) return;
        first = page - (p1 & mask);
        if (first > 64'(len)) first = 64'(len);
        push_exp(p1, 32'(first));
        rem = 64'(len) - first;
        if (rem == 0) return;
        if (p2 == 0) begin exp_fail = 1; return; end
        if (rem <= page) begin
            if ((p2 & mask) != 0) exp_fail = 1;
            else push_exp(p2, 32'(rem));
            return;
        end
        la = p2; i = 0;
        while (rem > 0) begin
            e = rd(la + 64'(i * 8));
            exp_reads++;
            if (e == 0 || (e & mask) != 0) begin exp_fail = 1; return; end
            if (i == epp - 1 && rem > page) begin
                la = e; i = 0;
            end else begin
                sl = (rem > page) ? page : rem;
                push_exp(e, 32'(sl));
                rem = rem - sl;
                i++;
            end
        end
    endtask

    // lay out list pages for a remainder, chaining at the last slot
    task automatic build_list(input logic [63:0] p2, input logic [63:0] rem_in, input int mi);
        logic [63:0] page, la, d, rem, nl;
        int epp, i, nxt;
        page = 64'(32) << mi;
        epp = int'(page / 8);
        la = p2; i = 0; d = DATA_BASE; rem = rem_in; nxt = 1; ent_n = 0;
        while (rem > 0) begin
            if (ent_n < 256) ent_at[ent_n] = la + 64'(i * 8);
            ent_n++;
            if (i == epp - 1 && rem > page) begin
                nl = LIST_BASE + 64'(nxt) * 64'h1000;
                nxt++;
                mem[la + 64'(i * 8)] = nl;
                la = nl; i = 0;
            end else begin
                mem[la + 64'(i * 8)] = d;
                d = d + page;
                rem = (rem > page) ? rem - page : 0;
                i++;
            end
        end
    endtask

    task automatic run(input logic [31:0] len, input logic [63:0] p1, input logic [63:0] p2,
                       input int mi, input string tag);
        int g;
        bit same;
        int bad;
        model(len, p1, p2, mi);
        @(posedge clk); #1;
        cap_n = 0; req_cnt = 0; done_cnt = 0; got_fail = 0; dnr_bad = 0;
        mps = MW'(mi); xfer_len = len; ptr_first = p1; ptr_second = p2;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        g = 0;
        while (done_cnt == 0 && g < 4000) begin @(posedge clk); g++; end
        repeat (3) @(posedge clk);
        same = (cap_n == exp_n);
        bad = -1;
        for (int k = 0; k < cap_n && k < 256 && same; k++)
            if (cap_a[k] != exp_a[k] || cap_l[k] != exp_l[k]) begin same = 0; bad = k; end
        if (bad >= 0)
            check(0, tag, "segment address at mismatch", longint'(cap_a[bad]), longint'(exp_a[bad]));
        else
            check(same, tag, "segment count", cap_n, exp_n);
        check(got_fail == exp_fail, tag, "fail flag", got_fail, exp_fail);
        check(req_cnt == exp_reads, "R9", "read requests", req_cnt, exp_reads);
        check(done_cnt == 1 && !dnr_bad, "R11", "done pulses", done_cnt, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] page, p1, p2, first, rem;
        logic [31:0] len;
        int offs [4];
        string tag;
        stall = 0;
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !seg_valid && !rd_req_valid && !done && !fail && !fail_dnr,
              "R11", "reset outputs idle", {busy, seg_valid, rd_req_valid, done, fail}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2: zero first pointer
        run(32'd100, 64'h0, DIRECT_ADDR, 0, "R2");
        // R3: zero length
        run(32'd0, 64'h4000, DIRECT_ADDR, 0, "R3");
        // R4: missing second pointer
        run(32'd40, 64'h4000, 64'h0, 0, "R4");
        run(32'd200, 64'h4008, 64'h0, 1, "R4");
        // R5: misaligned direct second pointer
        run(32'd50, 64'h4000, DIRECT_ADDR + 64'd8, 0, "R5");

        // main sweep over page size, first-pointer offset and length
        for (int mi = 0; mi < 2; mi++) begin
            page = 64'(32) << mi;
            offs[0] = 0; offs[1] = 8; offs[2] = int'(page) - 8; offs[3] = int'(page) - 1;
            stall = (mi == 1);
            for (int oi = 0; oi < 4; oi++) begin
                for (int k = 0; k <= int'(page / 8) * 4 + 3; k++) begin
                    len = 32'(k) * 32'(page / 2) + 32'(k % 3);
                    p1 = 64'h4000 + 64'(offs[oi]);
                    first = page - (p1 & (page - 1));
                    rem = (64'(len) > first) ? 64'(len) - first : 0;
                    mem.delete();
                    if (rem > page) begin
                        p2 = LIST_BASE;
                        build_list(p2, rem, mi);
                        tag = (rem > page * (page / 8 - 1)) ? "R7" : "R6";
                    end else begin
                        p2 = DIRECT_ADDR;
                        tag = (rem > 0) ? "R5" : "R3";
                    end
                    if (mi == 1) tag = {tag, " R1 R10"};
                    run(len, p1, p2, mi, tag);
                    if (exp_n > 0)
                        check(cap_n > 0 && cap_a[0] == p1 && cap_l[0] == exp_l[0],
                              (mi == 1) ? "R1 R3" : "R3", "first segment length",
                              longint'(cap_l[0]), longint'(exp_l[0]));
                end
            end
        end

        // R8: corrupt every written entry of a long chained list, zero and misaligned
        for (int mi = 0; mi < 2; mi++) begin
            page = 64'(32) << mi;
            stall = (mi == 0);
            len = 32'(page) * 32'(page / 8 * 3) + 32'd5;
            p1 = 64'h4010;
            first = page - (p1 & (page - 1));
            rem = 64'(len) - first;
            for (int v = 0; v < 2; v++) begin
                mem.delete();
                build_list(LIST_BASE, rem, mi);
                for (int j = 0; j < ent_n && j < 256; j++) begin
                    logic [63:0] keep;
                    mem.delete();
                    build_list(LIST_BASE, rem, mi);
                    keep = mem[ent_at[j]];
                    mem[ent_at[j]] = (v == 0) ? 64'h0 : keep + 64'd8;
                    run(len, p1, LIST_BASE, mi, "R8");
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule